// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block loads a downstream FPGA through its passive serial configuration pins. It comes out of reset on its own and holds the configuration request line low for a set number of cycles. After releasing that line it waits a second fixed interval instead of watching a status handshake. It then takes bytes from a valid/ready source and shifts each one out, most significant bit first, on a single data line. A configuration clock derived from the system clock samples that line.

The FPGA's done flag is checked at bit boundaries. When it is seen, the block stops taking bytes and raises a stop request to the source. It then issues a fixed number of extra clock pulses for device start-up and reports success. The block reports an error in two cases: the source signals end of data before the done flag arrives, or a cycle budget measured from reset runs out. Success and error are both terminal until the next reset. A single LED shows the state: it blinks while loading, stays lit on success, and is dark on error.

Top module: `ps_cfg_loader`

## Requirements
- R1: After reset is released, `cfg_n` stays low for exactly `PULSE_CYC` cycles and then goes high. No external trigger is needed.
- R2: After `cfg_n` goes high, `cfg_dclk` stays low for at least `WAIT_CYC` cycles. With a byte already offered, the first rising edge comes after exactly `WAIT_CYC + 1 + CLK_DIV/2` low cycles.
- R3: `cfg_dclk` has a period of `CLK_DIV` system cycles (even, at least 4). Each period is low for the first half and high for the second half.
- R4: Each accepted byte appears on `cfg_data` bit 7 first and bit 0 last. `cfg_data` changes only while `cfg_dclk` is low.
- R5: A byte is taken only on a cycle where `in_valid` and `in_ready` are both high. Each taken byte yields exactly eight `cfg_dclk` pulses.
- R6: When `cfg_done` is high at the end of a bit, or while the block waits for a byte, no further byte is accepted. `in_stop` rises, exactly `INIT_CLKS` more `cfg_dclk` pulses are issued, and then `cfg_ok` goes high.
- R7: If `in_last` is high while the block waits for a byte, `cfg_done` is low and no byte is offered, `cfg_err` goes high.
- R8: If loading has not finished, `cfg_err` goes high exactly `TIMEOUT_CYC` cycles after reset is released.
- R9: If `cfg_done` and `in_last` rise in the same cycle while the block waits for a byte, the done flag wins and the run ends in success.
- R10: While loading, `led` starts high and inverts every `BLINK_HALF` cycles. It is steady high with `cfg_ok` and steady low with `cfg_err`.
- R11: `cfg_ok` and `cfg_err` are never high together. Once either is high it stays high until reset, and `cfg_dclk` stays low.
- R12: During reset, `cfg_n` is low, `cfg_dclk`, `in_ready`, `in_stop`, `cfg_ok` and `cfg_err` are low, and `led` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte from the bitstream source |
| in_valid | input | 1 | Source offers `in_data` |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| in_last | input | 1 | Source has no more data |
| in_stop | output | 1 | Source may stop; loading has ended |
| cfg_n | output | 1 | Configuration request to the FPGA, active low |
| cfg_dclk | output | 1 | Configuration clock |
| cfg_data | output | 1 | Serial configuration data |
| cfg_done | input | 1 | FPGA reports configuration complete |
| cfg_ok | output | 1 | Terminal success |
| cfg_err | output | 1 | Terminal failure |
| led | output | 1 | Status lamp: blinking, on or off |

## Verification
Success detection and end-of-data detection can fall in the same cycle. Both are resolved in the byte-wait state. The bench shifts out a short stream and then holds back the end marker. Once the block sits waiting for a byte, the bench raises the done flag and the end marker together on one falling edge. The run is judged correct only if it ends in `cfg_ok` with no `cfg_err` and exactly the configured number of start-up pulses after it.

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader #(
  parameter int CLK_DIV     = 4,
  parameter int PULSE_CYC   = 3200,
  parameter int WAIT_CYC    = 64000,
  parameter int INIT_CLKS   = 16,
  parameter int TIMEOUT_CYC = 16000000,
  parameter int BLINK_HALF  = 40000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_last,
  output logic       in_stop,
  output logic       cfg_n,
  output logic       cfg_dclk,
  output logic       cfg_data,
  input  logic       cfg_done,
  output logic       cfg_ok,
  output logic       cfg_err,
  output logic       led
);

  localparam int HALF    = CLK_DIV / 2;
  localparam int DLY_MAX = (PULSE_CYC > WAIT_CYC) ? PULSE_CYC : WAIT_CYC;
  localparam int PW      = $clog2(CLK_DIV + 1);
  localparam int DW      = $clog2(DLY_MAX + 1);
  localparam int IW      = $clog2(INIT_CLKS + 1);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);
  localparam int BW      = $clog2(BLINK_HALF + 1);

  typedef enum logic [2:0] {
    S_PULSE, S_WAIT, S_FETCH, S_SHIFT, S_INIT, S_OK, S_ERR
  } state_t;

  state_t      st;
  logic [DW-1:0] dly;
  logic [PW-1:0] ph;
  logic [2:0]    bc;
  logic [IW-1:0] ic;
  logic [7:0]    sh;
  logic [TW-1:0] tmr;
  logic [BW-1:0] bcnt;
  logic          blink;

  logic running, tmo, ph_last;

  assign running = (st == S_PULSE) || (st == S_WAIT) || (st == S_FETCH) || (st == S_SHIFT);
  assign tmo     = running && (tmr == TW'(TIMEOUT_CYC - 1));
  assign ph_last = (ph == PW'(CLK_DIV - 1));

  assign cfg_n    = (st != S_PULSE);
  assign cfg_dclk = ((st == S_SHIFT) || (st == S_INIT)) && (ph >= PW'(HALF));
  assign cfg_data = sh[7];
  assign in_ready = (st == S_FETCH) && !cfg_done && !tmo;
  assign in_stop  = (st == S_INIT) || (st == S_OK) || (st == S_ERR);
  assign cfg_ok   = (st == S_OK);
  assign cfg_err  = (st == S_ERR);
  assign led      = cfg_ok ? 1'b1 : (cfg_err ? 1'b0 : blink);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt  <= '0;
      blink <= 1'b1;
      tmr   <= '0;
    end else begin
      if (running) tmr <= tmr + 1'b1;
      if ((st != S_OK) && (st != S_ERR)) begin
        if (bcnt == BW'(BLINK_HALF - 1)) begin
          bcnt  <= '0;
          blink <= ~blink;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_PULSE;
      dly <= '0;
      ph  <= '0;
      bc  <= '0;
      ic  <= '0;
      sh  <= '0;
    end else begin
      case (st)
        S_PULSE: begin
          if (tmo) st <= S_ERR;
          else if (dly == DW'(PULSE_CYC - 1)) begin
            dly <= '0;
            st  <= S_WAIT;
          end else dly <= dly + 1'b1;
        end
        S_WAIT: begin
          if (tmo) st <= S_ERR;
          else if (dly == DW'(WAIT_CYC - 1)) begin
            dly <= '0;
            st  <= S_FETCH;
          end else dly <= dly + 1'b1;
        end
        S_FETCH: begin
          if (cfg_done) begin
            ph <= '0;
            ic <= '0;
            st <= S_INIT;
          end else if (tmo) st <= S_ERR;
          else if (in_valid) begin
            sh <= in_data;
            bc <= '0;
            ph <= '0;
            st <= S_SHIFT;
          end else if (in_last) st <= S_ERR;
        end
        S_SHIFT: begin
          if (ph_last && cfg_done) begin
            ph <= '0;
            ic <= '0;
            st <= S_INIT;
          end else if (tmo) st <= S_ERR;
          else if (ph_last) begin
            ph <= '0;
            if (bc == 3'd7) st <= S_FETCH;
            else begin
              bc <= bc + 1'b1;
              sh <= {sh[6:0], 1'b0};
            end
          end else ph <= ph + 1'b1;
        end
        S_INIT: begin
          if (ph_last) begin
            ph <= '0;
            if (ic == IW'(INIT_CLKS - 1)) st <= S_OK;
            else ic <= ic + 1'b1;
          end else ph <= ph + 1'b1;
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic in_stop,
  input logic cfg_n,
  input logic cfg_dclk,
  input logic cfg_data,
  input logic cfg_ok,
  input logic cfg_err,
  input logic led
);

  p_no_dclk_in_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n |-> !cfg_dclk);

  p_dclk_high_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_dclk) |=> cfg_dclk);

  p_data_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dclk && $past(cfg_dclk)) |-> $stable(cfg_data));

  p_ready_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!cfg_dclk && cfg_n));

  p_stop_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> !in_ready);

  p_led_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> led);

  p_led_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !led);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err));

  p_ok_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> (cfg_ok && !cfg_dclk));

  p_err_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (cfg_err && !cfg_dclk));

endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .in_stop  (in_stop),
  .cfg_n    (cfg_n),
  .cfg_dclk (cfg_dclk),
  .cfg_data (cfg_data),
  .cfg_ok   (cfg_ok),
  .cfg_err  (cfg_err),
  .led      (led)
);

// File: tb/ps_cfg_loader_bench.sv
`timescale 1ns/1ps
module ps_cfg_loader_bench;

  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int PULSE   = 10;
  localparam int WAITC   = 30;
  localparam int INITC   = 16;
  localparam int TMO     = 400;
  localparam int BLINK   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0] in_data;
  logic in_valid, in_ready, in_last, in_stop;
  logic cfg_n, cfg_dclk, cfg_data, cfg_done, cfg_ok, cfg_err, led;

  logic [7:0] src [16];
  int   n_src = 0;
  int   idx = 0;
  logic end_en = 1'b0;
  logic force_last = 1'b0;
  logic clr = 1'b1;
  int   done_at = 1000;
  logic done_model = 1'b0;
  logic done_force = 1'b0;
  int   nbits = 0;
  int   init_rises = 0;
  logic [7:0] cap [16];

  int n_chk = 0;
  int n_err = 0;

  assign in_valid = (idx < n_src);
  assign in_data  = src[idx % 16];
  assign in_last  = (end_en && (idx >= n_src)) || force_last;
  assign cfg_done = done_model | done_force;

  ps_cfg_loader #(
    .CLK_DIV(CLK_DIV), .PULSE_CYC(PULSE), .WAIT_CYC(WAITC),
    .INIT_CLKS(INITC), .TIMEOUT_CYC(TMO), .BLINK_HALF(BLINK)
  ) u_ps_cfg_loader (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .in_last(in_last), .in_stop(in_stop),
    .cfg_n(cfg_n), .cfg_dclk(cfg_dclk), .cfg_data(cfg_data),
    .cfg_done(cfg_done), .cfg_ok(cfg_ok), .cfg_err(cfg_err), .led(led)
  );

  always @(posedge clk) begin
    if (clr) idx <= 0;
    else if (in_valid && in_ready) idx <= idx + 1;
  end

  always @(negedge clk) begin
    if (clr) done_model <= 1'b0;
    else if (nbits >= done_at) done_model <= 1'b1;
  end

  always @(posedge cfg_dclk or posedge clr) begin
    if (clr) begin
      nbits <= 0;
      init_rises <= 0;
      for (int i = 0; i < 16; i++) cap[i] <= 8'h00;
    end else if (!in_stop) begin
      cap[(nbits / 8) % 16] <= {cap[(nbits / 8) % 16][6:0], cfg_data};
      nbits <= nbits + 1;
    end else if (!cfg_ok) begin
      init_rises <= init_rises + 1;
    end
  end

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    clr = 1'b1;
    done_force = 1'b0;
    force_last = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_term(input int limit, output int cyc);
    cyc = 0;
    while (!cfg_ok && !cfg_err && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    n_src = 0; end_en = 1'b0; done_at = 1000;
    hold_reset();
    chk(cfg_n == 1'b0, "R12 cfg_n", cfg_n, 0);
    chk(cfg_dclk == 1'b0 && in_ready == 1'b0 && in_stop == 1'b0, "R12 dclk/ready/stop",
        {cfg_dclk, in_ready, in_stop}, 0);
    chk(cfg_ok == 1'b0 && cfg_err == 1'b0, "R12 ok/err", {cfg_ok, cfg_err}, 0);
    chk(led == 1'b1, "R12 led", led, 1);
  endtask

  task automatic t_success();
    int lowc, waitc, hi, lo, cyc;
    src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'hF0; src[3] = 8'h81;
    n_src = 4; end_en = 1'b1; done_at = 24;
    hold_reset();
    rst_n = 1'b1;
    lowc = 0;
    while (!cfg_n && lowc < 1000) begin lowc++; @(negedge clk); end
    chk(lowc == PULSE, "R1 config pulse width", lowc, PULSE);
    waitc = 0;
    while (!cfg_dclk && waitc < 1000) begin waitc++; @(negedge clk); end
    chk(waitc == WAITC + 1 + HALF, "R2 delay before first clock", waitc, WAITC + 1 + HALF);
    hi = 0;
    while (cfg_dclk && hi < 100) begin hi++; @(negedge clk); end
    lo = 0;
    while (!cfg_dclk && lo < 100) begin lo++; @(negedge clk); end
    chk(hi == HALF, "R3 clock high phase", hi, HALF);
    chk(lo == HALF, "R3 clock low phase", lo, HALF);
    wait_term(2000, cyc);
    chk(cfg_ok == 1'b1 && cfg_err == 1'b0, "R6 success reached", {cfg_ok, cfg_err}, 2);
    chk(cap[0] == 8'hA5, "R4 byte0 msb first", cap[0], 8'hA5);
    chk(cap[1] == 8'h3C, "R4 byte1 msb first", cap[1], 8'h3C);
    chk(cap[2] == 8'hF0, "R4 byte2 msb first", cap[2], 8'hF0);
    chk(nbits == 24, "R5 eight pulses per byte", nbits, 24);
    chk(idx == 3, "R6 no byte taken after done", idx, 3);
    chk(init_rises == INITC, "R6 init clock count", init_rises, INITC);
    chk(in_stop == 1'b1, "R6 stop raised", in_stop, 1);
    chk(led == 1'b1, "R10 led on at success", led, 1);
    repeat (50) @(negedge clk);
    chk(cfg_ok == 1'b1 && led == 1'b1 && cfg_dclk == 1'b0, "R11 success terminal",
        {cfg_ok, led, cfg_dclk}, 6);
    chk(idx == 3, "R6 source still untouched", idx, 3);
  endtask

  task automatic t_early_end();
    int cyc;
    src[0] = 8'h5A; src[1] = 8'hC3;
    n_src = 2; end_en = 1'b1; done_at = 1000;
    hold_reset();
    rst_n = 1'b1;
    wait_term(2000, cyc);
    chk(cfg_err == 1'b1 && cfg_ok == 1'b0, "R7 end without done is error", {cfg_ok, cfg_err}, 1);
    chk(cyc < TMO, "R7 error before timeout", cyc, TMO);
    chk(nbits == 16, "R7 all bytes shifted", nbits, 16);
    chk(cap[1] == 8'hC3, "R4 last byte", cap[1], 8'hC3);
    chk(led == 1'b0, "R10 led off at error", led, 0);
    repeat (40) @(negedge clk);
    chk(cfg_err == 1'b1 && led == 1'b0 && cfg_dclk == 1'b0, "R11 error terminal",
        {cfg_err, led, cfg_dclk}, 4);
  endtask

  task automatic t_timeout();
    logic l_a, l_b, l_c, l_d, e_a, e_b;
    n_src = 0; end_en = 1'b0; done_at = 1000;
    hold_reset();
    rst_n = 1'b1;
    l_a = 0; l_b = 0; l_c = 0; l_d = 0; e_a = 0; e_b = 0;
    for (int k = 0; k <= TMO; k++) begin
      if (k == BLINK - 1)     l_a = led;
      if (k == BLINK)         l_b = led;
      if (k == 2 * BLINK - 1) l_c = led;
      if (k == 2 * BLINK)     l_d = led;
      if (k == TMO - 1)       e_a = cfg_err;
      if (k == TMO)           e_b = cfg_err;
      @(negedge clk);
    end
    chk(l_a == 1'b1 && l_b == 1'b0, "R10 first blink toggle", {l_a, l_b}, 2);
    chk(l_c == 1'b0 && l_d == 1'b1, "R10 second blink toggle", {l_c, l_d}, 1);
    chk(e_a == 1'b0, "R8 no error before budget", e_a, 0);
    chk(e_b == 1'b1, "R8 error at budget", e_b, 1);
    chk(led == 1'b0 && cfg_ok == 1'b0, "R10 led off after timeout", {led, cfg_ok}, 0);
  endtask

  task automatic t_collide();
    int cyc;
    src[0] = 8'h11; src[1] = 8'hEE;
    n_src = 2; end_en = 1'b0; done_at = 1000;
    hold_reset();
    rst_n = 1'b1;
    cyc = 0;
    while (!(idx == 2 && in_ready) && cyc < 1000) begin cyc++; @(negedge clk); end
    chk(idx == 2 && in_ready == 1'b1, "R9 reached byte wait", idx, 2);
    done_force = 1'b1;
    force_last = 1'b1;
    wait_term(1000, cyc);
    chk(cfg_ok == 1'b1 && cfg_err == 1'b0, "R9 done beats end marker", {cfg_ok, cfg_err}, 2);
    chk(init_rises == INITC, "R9 init clocks after collision", init_rises, INITC);
    chk(nbits == 16, "R9 bits before collision", nbits, 16);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_success();
    t_early_end();
    t_timeout();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule